// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the 8-bit status byte of a serial memory and rules on every write the memory is asked to perform. A command decoder elsewhere hands it one-cycle strobes for the write-enable, write-disable and status-write commands, the status-write data byte, and the level of the active-low write-protect pin. The target address of a pending array write in a 32K-byte space also comes in. The block returns the current status byte, a flag that says whether the array byte at that address may be written, and a flag that says whether the status write strobed in this cycle is accepted.

The write-enable latch is a two-state machine. `WEL_CLEAR` is entered from reset. The `ARM` transition on a write-enable strobe moves it to `WEL_ARMED`. The `DISARM` transition, taken on a write-disable strobe, moves it back to `WEL_CLEAR`, and it wins when both strobes arrive together. With no strobe the `HOLD` transition keeps the state. The lock bit (bit 7), the two-bit region code (bits 3:2) and the user bits (6, 5, 4, 0) are plain flops loaded by accepted status writes. The region code selects a protected window that grows downward from the top of the address space. The array-write flag is combinational, so a burst can be judged byte by byte.

Top module: `sr_write_guard`

## Requirements
- R1: Reset, asynchronous and active low, forces the status byte to 0x00. While the status byte is 0x00, both `arr_wr_ok` and `sr_wr_accept` are 0.
- R2: A write-enable strobe sets bit 1 of the status byte (the enable latch) from the next cycle on. A write-disable strobe clears it from the next cycle on. When both strobes arrive in the same cycle, the latch ends cleared.
- R3: While bit 1 is 0, `arr_wr_ok` and `sr_wr_accept` are both 0, whatever the region code, address, pin or data.
- R4: `sr_wr_accept` is 1 in the cycle of a status-write strobe exactly when bit 1 is 1 and either bit 7 is 0 or `wprot_n` is 1. It is judged on the latch value before any enable or disable strobe of that same cycle takes effect.
- R5: An accepted status write loads bits 7..2 and bit 0 from `wrsr_data` in the next cycle. Data bit 1 is never loaded, so the latch is unaffected.
- R6: A rejected status write leaves the whole status byte unchanged.
- R7: With bit 1 set, bits 3:2 decide `arr_wr_ok` in the same cycle. Code 00 allows every address. Code 01 blocks 0x6000 to 0x7FFF. Code 10 blocks 0x4000 to 0x7FFF. Code 11 blocks every address.
- R8: The enable latch stays set after an accepted status write. It changes only through the two strobes and reset.
- R9: `sr_wr_accept` is 0 in every cycle without a status-write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| wprot_n | input | 1 | Write-protect pin level, low protects the lock bit |
| arr_addr | input | 15 | Address of the pending array write |
| status_byte | output | 8 | Current status byte |
| arr_wr_ok | output | 1 | Array write at `arr_addr` is allowed |
| sr_wr_accept | output | 1 | Status write in this cycle is accepted |

## Verification
A latch stuck in the wrong state shows at once on bit 1 of `status_byte`, one cycle after the strobe that should have moved it. It also flips `arr_wr_ok` in that same cycle for any address outside the protected window. A wrong lock or region bit shows in the cycle after the status write that stored it: it gives a wrong acceptance on the next status write under a low pin, or a wrong allow flag at one of the window edges 0x3FFF/0x4000 or 0x5FFF/0x6000. These edges, the simultaneous-strobe cases and the bit-1 data masking are therefore driven directly.

// File: rtl/sr_guard_pkg.sv
`timescale 1ns/1ps
package sr_guard_pkg;

    localparam int SR_W        = 8;
    localparam int BIT_LOCK    = 7;
    localparam int BIT_REG_HI  = 3;
    localparam int BIT_REG_LO  = 2;
    localparam int BIT_LATCH   = 1;

    localparam logic [SR_W-1:0] LATCH_MASK = logic'(1'b1) << BIT_LATCH;
    localparam logic [SR_W-1:0] STORE_MASK = ~LATCH_MASK;

    typedef enum logic {
        WEL_CLEAR = 1'b0,
        WEL_ARMED = 1'b1
    } wel_state_t;

    typedef enum logic [1:0] {
        REG_NONE    = 2'b00,
        REG_QUARTER = 2'b01,
        REG_HALF    = 2'b10,
        REG_ALL     = 2'b11
    } region_t;

endpackage

// File: rtl/sr_latch_fsm.sv
`timescale 1ns/1ps
module sr_latch_fsm
    import sr_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic disarm_i,
    output logic wel_o
);

    wel_state_t state_q;
    wel_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WEL_CLEAR: if (arm_i && !disarm_i) state_d = WEL_ARMED;
            WEL_ARMED: if (disarm_i)           state_d = WEL_CLEAR;
            default:                           state_d = WEL_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WEL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            WEL_ARMED: wel_o = 1'b1;
            default:   wel_o = 1'b0;
        endcase
    end

    AST_WEL_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && !disarm_i |=> wel_o); // R2
    AST_WEL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_i |=> !wel_o); // R2
    AST_WEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i && !disarm_i |=> $stable(wel_o)); // R8

endmodule

// File: rtl/sr_region_decode.sv
`timescale 1ns/1ps
module sr_region_decode
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              wel_i,
    input  logic [1:0]        region_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ok_o
);

    localparam int TOP = ADDR_W - 1;

    logic [1:0] top_bits;
    logic       blocked;

    assign top_bits = addr_i[TOP -: 2];

    always_comb begin
        unique case (region_t'(region_i))
            REG_NONE:    blocked = 1'b0;
            REG_QUARTER: blocked = (top_bits == 2'b11);
            REG_HALF:    blocked = top_bits[1];
            REG_ALL:     blocked = 1'b1;
            default:     blocked = 1'b1;
        endcase
        ok_o = wel_i && !blocked;
    end

endmodule

// File: rtl/sr_status_store.sv
`timescale 1ns/1ps
module sr_status_store
    import sr_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrsr_i,
    input  logic [SR_W-1:0] data_i,
    input  logic            wel_i,
    input  logic            pin_hi_i,
    output logic            accept_o,
    output logic [SR_W-1:0] store_o
);

    logic [SR_W-1:0] store_q;
    logic            lock_q;

    assign lock_q   = store_q[BIT_LOCK];
    assign accept_o = wrsr_i && wel_i && (!lock_q || pin_hi_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        store_q <= '0;
        else if (accept_o) store_q <= data_i & STORE_MASK;
    end

    assign store_o = store_q;

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |=> $stable(store_q)); // R6
    AST_LOCK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        store_q[BIT_LOCK] && !pin_hi_i |-> !accept_o); // R4
    AST_LOAD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> store_q[BIT_LOCK:BIT_REG_LO] == $past(data_i[BIT_LOCK:BIT_REG_LO])); // R5

endmodule

// File: rtl/sr_write_guard.sv
`timescale 1ns/1ps
module sr_write_guard
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              wprot_n,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status_byte,
    output logic              arr_wr_ok,
    output logic              sr_wr_accept
);

    logic            wel;
    logic [SR_W-1:0] store;

    sr_latch_fsm u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (cmd_wren),
        .disarm_i (cmd_wrdi),
        .wel_o    (wel)
    );

    sr_status_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrsr_i   (cmd_wrsr),
        .data_i   (wrsr_data),
        .wel_i    (wel),
        .pin_hi_i (wprot_n),
        .accept_o (sr_wr_accept),
        .store_o  (store)
    );

    sr_region_decode #(.ADDR_W(ADDR_W)) u_region (
        .wel_i    (wel),
        .region_i (store[BIT_REG_HI:BIT_REG_LO]),
        .addr_i   (arr_addr),
        .ok_o     (arr_wr_ok)
    );

    assign status_byte = store | (LATCH_MASK & {SR_W{wel}});

    AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[BIT_LATCH] |-> !arr_wr_ok && !sr_wr_accept); // R3
    AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[BIT_REG_HI:BIT_REG_LO] == 2'b11 |-> !arr_wr_ok); // R7
    AST_ACCEPT_ONLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wrsr |-> !sr_wr_accept); // R9
    AST_LATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_accept && !cmd_wrdi |=> status_byte[BIT_LATCH]); // R8

endmodule

// File: tb/sr_write_guard_test.sv
`timescale 1ns/1ps
module sr_write_guard_test;

    typedef struct packed {
        logic        wren;
        logic        wrdi;
        logic        wrsr;
        logic        pin;
        logic [7:0]  data;
        logic [14:0] addr;
        logic        acc;
        logic        ok;
        logic [7:0]  sb;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,8'h00,15'h0000,1'b0,1'b0,8'h00}, // 0  R3 idle, latch clear
        '{1'b0,1'b0,1'b1,1'b1,8'h8C,15'h0000,1'b0,1'b0,8'h00}, // 1  R3 R6 status write without latch
        '{1'b1,1'b0,1'b0,1'b0,8'h00,15'h0000,1'b0,1'b0,8'h02}, // 2  R2 arm
        '{1'b0,1'b0,1'b0,1'b0,8'h00,15'h7FFF,1'b0,1'b1,8'h02}, // 3  R7 code 00 top
        '{1'b0,1'b0,1'b1,1'b0,8'h04,15'h7FFF,1'b1,1'b1,8'h06}, // 4  R4 R5 R8 code 01
        '{1'b0,1'b0,1'b0,1'b0,8'h00,15'h6000,1'b0,1'b0,8'h06}, // 5  R7 quarter edge in
        '{1'b0,1'b0,1'b0,1'b0,8'h00,15'h5FFF,1'b0,1'b1,8'h06}, // 6  R7 quarter edge out
        '{1'b0,1'b0,1'b1,1'b0,8'h08,15'h4000,1'b1,1'b1,8'h0A}, // 7  R7 code 10
        '{1'b0,1'b0,1'b0,1'b0,8'h00,15'h4000,1'b0,1'b0,8'h0A}, // 8  R7 half edge in
        '{1'b0,1'b0,1'b0,1'b0,8'h00,15'h3FFF,1'b0,1'b1,8'h0A}, // 9  R7 half edge out
        '{1'b0,1'b0,1'b1,1'b0,8'h8C,15'h0000,1'b1,1'b1,8'h8E}, // 10 R5 lock + code 11
        '{1'b0,1'b0,1'b0,1'b0,8'h00,15'h0000,1'b0,1'b0,8'h8E}, // 11 R7 all blocked
        '{1'b0,1'b0,1'b1,1'b0,8'h00,15'h0000,1'b0,1'b0,8'h8E}, // 12 R4 R6 locked, pin low
        '{1'b0,1'b0,1'b1,1'b1,8'h70,15'h0000,1'b1,1'b0,8'h72}, // 13 R4 R5 pin high unlocks
        '{1'b0,1'b0,1'b0,1'b0,8'h00,15'h7FFF,1'b0,1'b1,8'h72}, // 14 R7 code 00
        '{1'b0,1'b0,1'b1,1'b1,8'h03,15'h7FFF,1'b1,1'b1,8'h03}, // 15 R5 data bit1 not loaded
        '{1'b0,1'b1,1'b0,1'b0,8'h00,15'h0000,1'b0,1'b1,8'h01}, // 16 R2 disarm
        '{1'b0,1'b0,1'b1,1'b1,8'hFF,15'h0000,1'b0,1'b0,8'h01}, // 17 R3 R6
        '{1'b1,1'b1,1'b0,1'b0,8'h00,15'h0000,1'b0,1'b0,8'h01}, // 18 R2 both strobes
        '{1'b1,1'b0,1'b0,1'b0,8'h00,15'h0000,1'b0,1'b0,8'h03}, // 19 R2 arm
        '{1'b0,1'b1,1'b1,1'b0,8'h00,15'h0000,1'b1,1'b1,8'h00}, // 20 R4 pre-cycle latch
        '{1'b0,1'b0,1'b1,1'b1,8'hFF,15'h0000,1'b0,1'b0,8'h00}  // 21 R3 R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren = 1'b0;
    logic        cmd_wrdi = 1'b0;
    logic        cmd_wrsr = 1'b0;
    logic [7:0]  wrsr_data = 8'h00;
    logic        wprot_n = 1'b0;
    logic [14:0] arr_addr = '0;
    logic [7:0]  status_byte;
    logic        arr_wr_ok;
    logic        sr_wr_accept;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sr_write_guard uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wren     (cmd_wren),
        .cmd_wrdi     (cmd_wrdi),
        .cmd_wrsr     (cmd_wrsr),
        .wrsr_data    (wrsr_data),
        .wprot_n      (wprot_n),
        .arr_addr     (arr_addr),
        .status_byte  (status_byte),
        .arr_wr_ok    (arr_wr_ok),
        .sr_wr_accept (sr_wr_accept)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic dis, input logic sw,
                         input logic pin, input logic [7:0] d, input logic [14:0] a);
        cmd_wren  = en;
        cmd_wrdi  = dis;
        cmd_wrsr  = sw;
        wprot_n   = pin;
        wrsr_data = d;
        arr_addr  = a;
    endtask

    initial begin
        #80000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset status", status_byte, 8'h00);
        chk("R1 reset array flag", {7'b0, arr_wr_ok}, 8'h00);
        chk("R1 reset accept", {7'b0, sr_wr_accept}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].wren, TBL[i].wrdi, TBL[i].wrsr, TBL[i].pin, TBL[i].data, TBL[i].addr);
            #1;
            chk($sformatf("vec %0d R4 R9 accept", i), {7'b0, sr_wr_accept}, {7'b0, TBL[i].acc});
            chk($sformatf("vec %0d R7 R3 array flag", i), {7'b0, arr_wr_ok}, {7'b0, TBL[i].ok});
            @(posedge clk);
            #1;
            chk($sformatf("vec %0d R2 R5 R6 status", i), status_byte, TBL[i].sb);
        end

        // R9: all conditions met but no strobe
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 15'h0000);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 15'h0000);
        #1;
        chk("R9 no strobe no accept", {7'b0, sr_wr_accept}, 8'h00);
        chk("R7 code 00 low address", {7'b0, arr_wr_ok}, 8'h01);

        // R8: latch kept across several accepted writes
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h8D, 15'h0000);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 15'h0000);
        #1;
        chk("R8 latch after status write", status_byte, 8'h8F);

        // R1: asynchronous reset mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset status", status_byte, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 15'h1234);
        #1;
        chk("R3 after reset accept", {7'b0, sr_wr_accept}, 8'h00);
        chk("R3 after reset array flag", {7'b0, arr_wr_ok}, 8'h00);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 15'h0000);
        chk("R6 after reset rejected", status_byte, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule